// File: doc/BRIEF.md
# Gated Synchronous Frame Receiver with Word Unpacker

This block receives one 72-bit frame from a synchronous serial link in which a gate line frames the data. A frame begins only when the gate rises; an idle line going from low to data is never taken as a start. The receiver runs on the system clock and counts a 16x oversampling enable. It takes its first sample half a bit after the gate rises, then one sample per bit, so that every bit is read near its middle. Bits arrive most significant first.

Once a full frame has arrived it is handed to an unpacker. The unpacker presents the frame to a host as five 16-bit words on a parallel bus. The first word carries the top 8 frame bits zero-extended, and one interrupt pulse marks each new word. A one-cycle done flag follows the fifth word. If the gate falls before all 72 bits are in, the frame is dropped without a trace.

The receiver FSM has four states. RX_IDLE moves to RX_MID on a synchronized gate rise. RX_MID moves to RX_BITS at the first sample. RX_BITS moves to RX_HOLD at the 72nd sample. RX_HOLD moves back to RX_IDLE when the gate falls. RX_MID and RX_BITS abort to RX_IDLE whenever the gate is low. The unpacker FSM also has four states. EM_IDLE moves to EM_PULSE when a frame arrives. EM_PULSE moves to EM_GAP after the pulse length. EM_GAP returns to EM_PULSE for the next word, or moves to EM_DONE after the last word. EM_DONE returns to EM_IDLE.

Top module: `gated_frame_rx`

## Requirements
- R1: With the gate low, no activity on the data line ever produces a word, an interrupt or a done flag.
- R2: After the two-flop synchronizer sees the gate rise, the first bit is sampled 8 oversampling ticks later and each later bit 16 ticks after the previous one. Clock cycles without the tick enable are not counted, so the tick rate may be any fraction of the clock.
- R3: A frame is 72 bits, and the first bit received becomes the most significant bit of the frame.
- R4: The frame is emitted as five 16-bit words, high part first. Word 0 is 8 zero bits followed by frame bits 71:64, and words 1 to 4 are bits 63:48, 47:32, 31:16 and 15:0. Frame 0x02123456789abcde03 gives 0x0002, 0x1234, 0x5678, 0x9abc, 0xde03.
- R5: Each word is marked by exactly one interrupt pulse that is high for IRQ_LEN cycles (default 2). Consecutive pulses are separated by IRQ_LEN low cycles, and a new word appears on the bus in the cycle its pulse rises.
- R6: The word bus changes only in a cycle in which the interrupt rises, and otherwise holds its value, including after the last word of a frame.
- R7: After the fifth pulse of a frame, the done flag is high for exactly one cycle, never together with the interrupt.
- R8: If the gate falls before the 72nd sample, the frame is discarded: no word, no interrupt and no done flag. The next gate rise starts a new frame normally.
- R9: After its 72nd bit the receiver ignores the line until the gate falls. A new frame may begin while the words of the previous one are still being emitted, and both frames are delivered intact.
- R10: During and right after reset the word bus is 0, and the interrupt and done flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Oversampling enable, 16 per bit period |
| ser_data | input | 1 | Serial data line, MSB first |
| ser_gate | input | 1 | Frame gate; rising edge starts a frame |
| word_out | output | 16 | Current 16-bit word for the host |
| word_irq | output | 1 | Interrupt pulse, one per new word |
| frame_done | output | 1 | One-cycle flag after the last word of a frame |

## Verification
Two functions can be active in the same cycle: the unpacker streaming out the words of a finished frame, and the receiver detecting the next gate rise and counting toward that frame's first sample. The bench provokes this by dropping the gate for only two cycles after a frame and raising it again at once, so the next frame starts during the emission of the previous one. It then requires all ten words, in order, with correct pulse widths and exactly two done flags. A second pairing puts a gate fall on a receiver that has taken only some of the bits. That frame must vanish, and the frame sent straight after it must come out correctly.

// File: rtl/gfr_pkg.sv
package gfr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_MID,
        RX_BITS,
        RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        EM_IDLE,
        EM_PULSE,
        EM_GAP,
        EM_DONE
    } em_state_t;

endpackage

// File: rtl/gfr_sync.sv
module gfr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= '0;
                else        chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gfr_bit_rx.sv
module gfr_bit_rx
    import gfr_pkg::*;
#(
    parameter int FRAME_BITS = 72,
    parameter int OVS        = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic                  data_s,
    input  logic                  gate_s,
    output logic                  frame_full,
    output logic [FRAME_BITS-1:0] frame_bits
);
    localparam int TW = (OVS > 2) ? $clog2(OVS) : 1;
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam logic [TW-1:0] MID_T = TW'(OVS/2 - 1);
    localparam logic [TW-1:0] BIT_T = TW'(OVS - 1);
    localparam logic [BW-1:0] LAST_B = BW'(FRAME_BITS - 1);

    rx_state_t state, nxt;
    logic          gate_q;
    logic          gate_rise;
    logic [TW-1:0] tcnt;
    logic [BW-1:0] bcnt;
    logic          hit;
    logic          last;
    logic          active;
    logic          sample_stb;

    assign gate_rise  = gate_s & ~gate_q;
    assign active     = (state == RX_MID) || (state == RX_BITS);
    assign hit        = tick_en && (tcnt == ((state == RX_MID) ? MID_T : BIT_T));
    assign last       = (bcnt == LAST_B);
    assign sample_stb = active && gate_s && hit;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: if (gate_rise) nxt = RX_MID;
            RX_MID, RX_BITS: begin
                if (!gate_s)  nxt = RX_IDLE;
                else if (hit) nxt = last ? RX_HOLD : RX_BITS;
            end
            RX_HOLD: if (!gate_s) nxt = RX_IDLE;
            default: nxt = RX_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q     <= 1'b0;
            tcnt       <= '0;
            bcnt       <= '0;
            frame_bits <= '0;
            frame_full <= 1'b0;
        end else begin
            gate_q     <= gate_s;
            frame_full <= sample_stb && last;
            if (!active) begin
                tcnt <= '0;
                bcnt <= '0;
            end else if (gate_s && tick_en) begin
                tcnt <= hit ? '0 : tcnt + 1'b1;
            end
            if (sample_stb) begin
                frame_bits <= {frame_bits[FRAME_BITS-2:0], data_s};
                bcnt       <= bcnt + 1'b1;
            end
        end
    end

    // R8: a gate drop during collection returns the receiver to idle
    p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !gate_s) |=> (state == RX_IDLE));

    // R9: once complete, the receiver waits for the gate to fall
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && gate_s) |=> (state == RX_HOLD));

    // R3: a completed frame is reported only from the holding state
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_full |-> (state == RX_HOLD || state == RX_IDLE));
endmodule

// File: rtl/gfr_word_emit.sv
module gfr_word_emit
    import gfr_pkg::*;
#(
    parameter int FRAME_BITS = 72,
    parameter int WORD_W     = 16,
    parameter int IRQ_LEN    = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame_bits,
    output logic [WORD_W-1:0]     word_out,
    output logic                  word_irq,
    output logic                  frame_done,
    output logic                  busy
);
    localparam int NUM_WORDS = (FRAME_BITS + WORD_W - 1) / WORD_W;
    localparam int BUF_W     = NUM_WORDS * WORD_W;
    localparam int LW        = $clog2(IRQ_LEN + 1);
    localparam int CW        = $clog2(NUM_WORDS + 1);
    localparam logic [LW-1:0] LEN_T  = LW'(IRQ_LEN - 1);
    localparam logic [CW-1:0] LAST_W = CW'(NUM_WORDS - 1);

    em_state_t state, nxt;
    logic [BUF_W-1:0] buf_q;
    logic [BUF_W-1:0] ext;
    logic [LW-1:0]    lcnt;
    logic [CW-1:0]    wcnt;
    logic             len_end;

    assign ext     = BUF_W'(frame_bits);
    assign len_end = (lcnt == LEN_T);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= EM_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            EM_IDLE:  if (load) nxt = EM_PULSE;
            EM_PULSE: if (len_end) nxt = EM_GAP;
            EM_GAP:   if (len_end) nxt = (wcnt == LAST_W) ? EM_DONE : EM_PULSE;
            EM_DONE:  nxt = EM_IDLE;
            default:  nxt = EM_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q    <= '0;
            word_out <= '0;
            lcnt     <= '0;
            wcnt     <= '0;
        end else begin
            lcnt <= (nxt != state) ? '0 : lcnt + 1'b1;
            if (state == EM_IDLE && load) begin
                word_out <= ext[BUF_W-1 -: WORD_W];
                buf_q    <= ext << WORD_W;
                wcnt     <= '0;
            end else if (state == EM_GAP && nxt == EM_PULSE) begin
                word_out <= buf_q[BUF_W-1 -: WORD_W];
                buf_q    <= buf_q << WORD_W;
                wcnt     <= wcnt + 1'b1;
            end
        end
    end

    assign word_irq   = (state == EM_PULSE);
    assign frame_done = (state == EM_DONE);
    assign busy       = (state != EM_IDLE);

    // R6: the word bus moves only together with a rising interrupt
    p_word_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(word_out) |-> $rose(word_irq));

    // R7: done is a single-cycle flag
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R7: done and interrupt never coincide
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !word_irq);

    // R9: a new frame never lands while words are still going out
    p_no_overrun_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state == EM_IDLE));

    if (IRQ_LEN > 1) begin : g_width
        // R5: a pulse never lasts a single cycle when IRQ_LEN exceeds one
        p_irq_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(word_irq) |=> word_irq);
    end
endmodule

// File: rtl/gated_frame_rx.sv
module gated_frame_rx
    import gfr_pkg::*;
#(
    parameter int FRAME_BITS  = 72,
    parameter int WORD_W      = 16,
    parameter int OVS         = 16,
    parameter int IRQ_LEN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ser_data,
    input  logic              ser_gate,
    output logic [WORD_W-1:0] word_out,
    output logic              word_irq,
    output logic              frame_done
);
    logic [1:0]            sync_q;
    logic                  full;
    logic [FRAME_BITS-1:0] bits;
    logic                  em_busy;

    gfr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_gate, ser_data}),
        .q     (sync_q)
    );

    gfr_bit_rx #(.FRAME_BITS(FRAME_BITS), .OVS(OVS)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .data_s     (sync_q[0]),
        .gate_s     (sync_q[1]),
        .frame_full (full),
        .frame_bits (bits)
    );

    gfr_word_emit #(.FRAME_BITS(FRAME_BITS), .WORD_W(WORD_W), .IRQ_LEN(IRQ_LEN)) u_em (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (full),
        .frame_bits (bits),
        .word_out   (word_out),
        .word_irq   (word_irq),
        .frame_done (frame_done),
        .busy       (em_busy)
    );

    // R1: nothing is emitted unless a frame has been loaded
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!em_busy && !full) |=> !word_irq);
endmodule

// File: tb/sim_gated_frame_rx.sv
`timescale 1ns/1ps
module sim_gated_frame_rx;
    localparam int IRQ_LEN = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        ser_data = 1'b0;
    logic        ser_gate = 1'b0;
    logic [15:0] word_out;
    logic        word_irq;
    logic        frame_done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 0;

    // monitor state
    logic [15:0] got [16];
    int  ngot = 0;
    int  done_cnt = 0;
    int  done_at = 0;
    int  bad_width = 0;
    int  unstable = 0;
    int  wcur = 0;
    logic irq_d = 1'b0;
    logic [15:0] prev_word = '0;

    always #2.5 clk = ~clk;

    gated_frame_rx u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .ser_data   (ser_data),
        .ser_gate   (ser_gate),
        .word_out   (word_out),
        .word_irq   (word_irq),
        .frame_done (frame_done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (word_irq && !irq_d) begin
                if (ngot < 16) got[ngot] = word_out;
                ngot++;
                wcur = 0;
            end else if (word_out !== prev_word) begin
                unstable++;
            end
            if (word_irq) wcur++;
            if (!word_irq && irq_d && wcur != IRQ_LEN) bad_width++;
            if (frame_done) begin
                done_cnt++;
                done_at = ngot;
                if (word_irq) bad_width++;
            end
            irq_d     = word_irq;
            prev_word = word_out;
        end
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        ngot = 0; done_cnt = 0; done_at = 0; bad_width = 0; unstable = 0;
    endtask

    task automatic idle(input int n, input int rate, input bit noise);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en  = ((i % rate) == 0);
            ser_gate = 1'b0;
            ser_data = noise ? i[2] : 1'b0;
        end
    endtask

    task automatic send(input logic [71:0] f, input int rate, input int nbits);
        for (int b = 0; b < nbits; b++)
            for (int t = 0; t < 16; t++)
                for (int k = 0; k < rate; k++) begin
                    @(negedge clk);
                    tick_en  = (k == 0);
                    ser_gate = 1'b1;
                    ser_data = f[71-b];
                end
    endtask

    function automatic logic [15:0] exp_word(input logic [71:0] f, input int i);
        logic [79:0] e;
        e = {8'h00, f};
        return e[79-16*i -: 16];
    endfunction

    // compare a run of frames against what the monitor collected
    task automatic judge(input logic [71:0] fa, input logic [71:0] fb, input int nfr, input string tag);
        check("R5", {tag, " word count"}, ngot, 5*nfr);
        for (int fi = 0; fi < nfr; fi++)
            for (int i = 0; i < 5; i++)
                if (5*fi+i < ngot && 5*fi+i < 16)
                    check("R4", $sformatf("%s frame %0d word %0d", tag, fi, i),
                          got[5*fi+i], exp_word(fi == 0 ? fa : fb, i));
        check("R7", {tag, " done count"}, done_cnt, nfr);
        check("R7", {tag, " done after last word"}, done_at, 5*nfr);
        check("R5", {tag, " pulse widths"}, bad_width, 0);
        check("R6", {tag, " bus stability"}, unstable, 0);
    endtask

    task automatic one_frame(input logic [71:0] f, input int rate, input string tag);
        clear_mon();
        send(f, rate, 72);
        idle(80, rate, 1'b0);
        judge(f, f, 1, tag);
    endtask

    initial begin
        logic [71:0] fa, fb;
        repeat (4) @(negedge clk);
        // R10: reset values
        check("R10", "word during reset", word_out, 0);
        check("R10", "irq during reset", word_irq, 0);
        check("R10", "done during reset", frame_done, 0);
        rst_n = 1'b1;
        idle(4, 1, 1'b0);
        check("R10", "word after reset", word_out, 0);
        check("R10", "irq after reset", word_irq, 0);

        // R1: data noise with gate low
        clear_mon();
        idle(300, 1, 1'b1);
        check("R1", "words with gate low", ngot, 0);
        check("R1", "done with gate low", done_cnt, 0);

        // R4: reference vector, R3 MSB first
        one_frame(72'h02123456789abcde03, 1, "R3 R4 example");
        check("R6", "last word held", word_out, 16'hde03);

        // patterns
        one_frame('0, 1, "zeros");
        one_frame('1, 1, "ones");
        one_frame({9{8'hA5}}, 1, "alt");
        for (int p = 0; p < 72; p += 4)
            one_frame(72'h1 << p, 1, $sformatf("R3 walk %0d", p));
        for (int p = 1; p < 72; p += 10)
            one_frame(~(72'h1 << p), 1, $sformatf("R3 walk0 %0d", p));

        // R2: tick enable slower than clock
        one_frame(72'h5a_c3e1_0f96_7b2d_84ee, 2, "R2 rate2");
        one_frame(72'h81_7e00_ff12_3456_cafe, 3, "R2 rate3");
        one_frame(72'h3c_9999_6666_0001_8000, 5, "R2 rate5");

        // R8: abort, then a clean frame
        clear_mon();
        send(72'hff_ffff_ffff_ffff_ffff, 1, 40);
        idle(200, 1, 1'b0);
        check("R8", "words after abort", ngot, 0);
        check("R8", "done after abort", done_cnt, 0);
        send(72'h11_2233_4455_6677_8899, 2, 71);
        idle(200, 2, 1'b0);
        check("R8", "words after 71-bit abort", ngot, 0);
        one_frame(72'h9e_0102_0304_0506_0708, 1, "R8 after abort");

        // R9: back-to-back, next frame starts during word emission
        fa = 72'hc4_dead_beef_1234_5678;
        fb = 72'h07_a1b2_c3d4_e5f6_0918;
        clear_mon();
        send(fa, 1, 72);
        idle(2, 1, 1'b0);
        send(fb, 1, 72);
        idle(80, 1, 1'b0);
        judge(fa, fb, 2, "R9 back-to-back");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            vectors++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule